// File: doc/BRIEF.md
# Four-Master Three-Slave Crossbar Switch with Per-Port Arbitration

This block joins four bus masters to three slave ports. Every master carries a 32-bit address, a 64-bit write path and a 64-bit read path. The top four address bits choose a slave port. Masters that target different slaves are served in the same cycles, so up to three transfers run at once. A master whose address falls in no slave window gets an immediate error response and never takes a port.

Each slave port has its own arbiter. A per-port mode bit selects how the arbiter picks a winner. In programmed-order mode, a configuration field gives each master a 2-bit level, and the largest level wins. In rotating mode, the winner is the first requester after the master granted last. Any master can raise its priority by holding its elevation input. Elevated requesters always beat non-elevated ones, and the per-port mode breaks ties among them.

A grant belongs to one multi-beat transaction. The owning master keeps the port until a beat that it marks as last is accepted by the slave. The losing masters wait until then.

Top module: `xbar_switch`

## Requirements
- R1: The slave port is chosen by address bits [31:28]: value 0x0 selects slave 0, 0x2 selects slave 1 and 0x4 selects slave 2.
- R2: A requesting master whose address bits [31:28] hold any other value sees m_err and m_ready high in the same cycle as its request, and it owns no slave port.
- R3: A request to an idle slave port is granted at the next clock edge: s_sel rises one cycle after the request, and s_mid names the granted master (masters numbered 0 to 3).
- R4: The owner keeps the port until the slave accepts a beat with the owner's m_last high (s_ready and s_last both high). In the cycle after that beat the port is idle, and it is granted again only one edge later.
- R5: When cfg_rr is 0 for a port, the arbiter grants the requester with the largest 2-bit level. Master m's level for slave s is cfg_prio[(s*4+m)*2 +: 2]. Software keeps the four levels of a port distinct.
- R6: When cfg_rr is 1 for a port, the arbiter grants the first requester found by counting upward from the last granted master and wrapping from 3 to 0. After reset, the last granted master is taken to be 3.
- R7: A requester with m_elev high beats every requester without it. Among elevated requesters the port's current mode decides.
- R8: Ports serving different masters are granted and run in the same cycles without affecting each other.
- R9: A selected port carries its owner's address, write flag, write data and last flag. Only the owner of a port sees that port's s_ready on m_ready and its s_rdata on m_rdata. A waiting master sees m_ready low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rr | input | 3 | Per-port mode: 1 rotating, 0 programmed order |
| cfg_prio | input | 24 | 2-bit level per port and master |
| m_req | input | 4 | Master request, held through the transaction |
| m_elev | input | 4 | Master priority elevation |
| m_addr | input | 128 | Master addresses, 32 bits each |
| m_we | input | 4 | Master write flag |
| m_wdata | input | 256 | Master write data, 64 bits each |
| m_last | input | 4 | Master marks the current beat as last |
| m_ready | output | 4 | Beat accepted, or error response |
| m_err | output | 4 | Address hits no slave |
| m_rdata | output | 256 | Read data routed back to each master |
| s_sel | output | 3 | Port owned and active |
| s_mid | output | 6 | Owner master index, 2 bits per port |
| s_addr | output | 96 | Address to each slave |
| s_we | output | 3 | Write flag to each slave |
| s_wdata | output | 192 | Write data to each slave |
| s_last | output | 3 | Last-beat flag to each slave |
| s_ready | input | 3 | Slave accepts the current beat |
| s_rdata | input | 192 | Slave read data |

## Verification
The hardest cases to reach are those where several masters compete for one port. Rotating order, programmed levels and elevation are only observable as the sequence of grants, and this needs every competing request to be pending at the same edge. The stimulus raises all competing requests in one cycle, keeps the slaves ready, and releases each master after the cycle in which its single last beat is accepted. A scoreboard holds the grant order worked out in advance for each port and compares it with the s_mid value at every rising s_sel. One case holds a multi-beat owner while a higher-level master waits, to show that the waiting master gets no grant until the last beat is accepted.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int unsigned XB_MASTERS = 4;
  localparam int unsigned XB_SLAVES  = 3;
  localparam int unsigned XB_AW      = 32;
  localparam int unsigned XB_DW      = 64;
  localparam int unsigned XB_LVLW    = 2;   // priority level width
  localparam int unsigned XB_REGW    = 4;   // decoded high address bits
  // region code per slave, slave 0 in the low nibble
  localparam logic [XB_SLAVES*XB_REGW-1:0] XB_REGION = {4'h4, 4'h2, 4'h0};
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int unsigned AW     = 32,
  parameter int unsigned N_SLV  = 3,
  parameter int unsigned REGW   = 4,
  parameter logic [N_SLV*REGW-1:0] REGION = '0,
  localparam int unsigned SW    = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [SW-1:0] sidx
);
  logic [REGW-1:0] field;
  assign field = addr[AW-1 -: REGW];

  always_comb begin
    hit  = 1'b0;
    sidx = '0;
    for (int s = 0; s < N_SLV; s++) begin
      if (field == REGION[s*REGW +: REGW]) begin
        hit  = 1'b1;
        sidx = SW'(s);
      end
    end
  end
endmodule

// File: rtl/xbar_arbiter.sv
module xbar_arbiter #(
  parameter int unsigned N_MST = 4,
  parameter int unsigned LVLW  = 2,
  localparam int unsigned MW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_MST-1:0]      req,
  input  logic [N_MST-1:0]      elev,
  input  logic                  rr_mode,
  input  logic [N_MST*LVLW-1:0] prio,
  input  logic                  done,
  output logic                  busy,
  output logic [MW-1:0]         owner
);
  logic             busy_q, busy_d;
  logic [MW-1:0]    own_q, last_q, win;
  logic [N_MST-1:0] cand;
  logic [LVLW-1:0]  best;
  logic [MW-1:0]    idx;
  logic             found, grant_en;

  // candidate set: elevated requesters shadow the others
  always_comb begin
    cand  = (|(req & elev)) ? (req & elev) : req;
    win   = '0;
    found = 1'b0;
    best  = '0;
    idx   = '0;
    if (rr_mode) begin
      for (int k = 1; k <= N_MST; k++) begin
        idx = MW'((int'(last_q) + k) % N_MST);
        if (!found && cand[idx]) begin
          found = 1'b1;
          win   = idx;
        end
      end
    end else begin
      for (int i = 0; i < N_MST; i++) begin
        if (cand[i] && (!found || prio[i*LVLW +: LVLW] > best)) begin
          found = 1'b1;
          win   = MW'(i);
          best  = prio[i*LVLW +: LVLW];
        end
      end
    end
  end

  always_comb begin
    grant_en = !busy_q && found;
    busy_d   = busy_q;
    if (busy_q) begin
      if (done) busy_d = 1'b0;
    end else if (found) begin
      busy_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      own_q  <= '0;
      last_q <= MW'(N_MST - 1);
    end else begin
      busy_q <= busy_d;
      if (grant_en) begin
        own_q  <= win;
        last_q <= win;
      end
    end
  end

  assign busy  = busy_q;
  assign owner = own_q;
endmodule

// File: rtl/xbar_switch.sv
module xbar_switch
  import xbar_pkg::*;
#(
  parameter int unsigned N_MST = XB_MASTERS,
  parameter int unsigned N_SLV = XB_SLAVES,
  parameter int unsigned AW    = XB_AW,
  parameter int unsigned DW    = XB_DW,
  parameter int unsigned LVLW  = XB_LVLW,
  parameter int unsigned REGW  = XB_REGW,
  parameter logic [N_SLV*REGW-1:0] REGION = XB_REGION,
  localparam int unsigned MW   = (N_MST > 1) ? $clog2(N_MST) : 1,
  localparam int unsigned SW   = (N_SLV > 1) ? $clog2(N_SLV) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_SLV-1:0]            cfg_rr,
  input  logic [N_SLV*N_MST*LVLW-1:0] cfg_prio,
  input  logic [N_MST-1:0]            m_req,
  input  logic [N_MST-1:0]            m_elev,
  input  logic [N_MST*AW-1:0]         m_addr,
  input  logic [N_MST-1:0]            m_we,
  input  logic [N_MST*DW-1:0]         m_wdata,
  input  logic [N_MST-1:0]            m_last,
  output logic [N_MST-1:0]            m_ready,
  output logic [N_MST-1:0]            m_err,
  output logic [N_MST*DW-1:0]         m_rdata,
  output logic [N_SLV-1:0]            s_sel,
  output logic [N_SLV*MW-1:0]         s_mid,
  output logic [N_SLV*AW-1:0]         s_addr,
  output logic [N_SLV-1:0]            s_we,
  output logic [N_SLV*DW-1:0]         s_wdata,
  output logic [N_SLV-1:0]            s_last,
  input  logic [N_SLV-1:0]            s_ready,
  input  logic [N_SLV*DW-1:0]         s_rdata
);
  logic [N_MST-1:0] hit;
  logic [SW-1:0]    sidx [N_MST];
  logic [MW-1:0]    own  [N_SLV];
  logic [N_SLV-1:0] busy;

  for (genvar m = 0; m < N_MST; m++) begin : g_dec
    xbar_decode #(.AW(AW), .N_SLV(N_SLV), .REGW(REGW), .REGION(REGION)) u_dec (
      .addr (m_addr[m*AW +: AW]),
      .hit  (hit[m]),
      .sidx (sidx[m])
    );
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_port
    logic [N_MST-1:0] req_here;
    logic             done;

    always_comb begin
      for (int m = 0; m < N_MST; m++)
        req_here[m] = m_req[m] && hit[m] && (sidx[m] == SW'(s));
    end

    assign done = busy[s] && s_ready[s] && m_last[own[s]];

    xbar_arbiter #(.N_MST(N_MST), .LVLW(LVLW)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_here),
      .elev    (m_elev),
      .rr_mode (cfg_rr[s]),
      .prio    (cfg_prio[s*N_MST*LVLW +: N_MST*LVLW]),
      .done    (done),
      .busy    (busy[s]),
      .owner   (own[s])
    );

    assign s_sel[s]              = busy[s];
    assign s_mid[s*MW +: MW]     = own[s];
    assign s_addr[s*AW +: AW]    = m_addr[own[s]*AW +: AW];
    assign s_we[s]               = m_we[own[s]];
    assign s_wdata[s*DW +: DW]   = m_wdata[own[s]*DW +: DW];
    assign s_last[s]             = m_last[own[s]];
  end

  // response routing back to the owning master
  always_comb begin
    m_rdata = '0;
    for (int m = 0; m < N_MST; m++) begin
      m_err[m]   = m_req[m] && !hit[m];
      m_ready[m] = m_err[m];
      for (int s = 0; s < N_SLV; s++) begin
        if (busy[s] && own[s] == MW'(m)) begin
          m_ready[m]            = s_ready[s];
          m_rdata[m*DW +: DW]   = s_rdata[s*DW +: DW];
        end
      end
    end
  end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
  parameter int unsigned N_MST = 4,
  parameter int unsigned N_SLV = 3,
  parameter int unsigned MW    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_MST-1:0]    m_req,
  input logic [N_MST-1:0]    m_err,
  input logic [N_MST-1:0]    m_ready,
  input logic [N_SLV-1:0]    s_sel,
  input logic [N_SLV*MW-1:0] s_mid,
  input logic [N_SLV-1:0]    s_ready,
  input logic [N_SLV-1:0]    s_last
);
  logic [N_MST-1:0] req_q;
  logic [N_MST-1:0] owned;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= m_req;
  end

  always_comb begin
    owned = '0;
    for (int s = 0; s < N_SLV; s++)
      if (s_sel[s]) owned[s_mid[s*MW +: MW]] = 1'b1;
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_chk_port
    // R4: owner and selection stay put until the last beat is accepted
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel[s] && !(s_ready[s] && s_last[s])) |=> (s_sel[s] && $stable(s_mid[s*MW +: MW])));
    // R4: port drops for one cycle after the last beat
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel[s] && s_ready[s] && s_last[s]) |=> !s_sel[s]);
    // R3: a new owner was requesting at the granting edge
    p_grant_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s_sel[s]) |-> req_q[s_mid[s*MW +: MW]]);
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_chk_mst
    // R2: an error response never coexists with port ownership
    p_err_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> !owned[m]);
    // R9: a non-error ready only reaches an owner
    p_ready_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_ready[m] && !m_err[m]) |-> owned[m]);
  end
endmodule

bind xbar_switch xbar_checker #(.N_MST(N_MST), .N_SLV(N_SLV), .MW(MW)) u_xbar_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .m_req   (m_req),
  .m_err   (m_err),
  .m_ready (m_ready),
  .s_sel   (s_sel),
  .s_mid   (s_mid),
  .s_ready (s_ready),
  .s_last  (s_last)
);

// File: tb/xbar_switch_bench.sv
`timescale 1ns/1ps
module xbar_switch_bench;
  localparam int NM = 4, NS = 3, AW = 32, DW = 64, MW = 2;

  logic              clk, rst_n;
  logic [NS-1:0]     cfg_rr;
  logic [NS*NM*2-1:0] cfg_prio;
  logic [NM-1:0]     m_req, m_elev, m_we, m_last, m_ready, m_err;
  logic [NM*AW-1:0]  m_addr;
  logic [NM*DW-1:0]  m_wdata, m_rdata;
  logic [NS-1:0]     s_sel, s_we, s_last, s_ready;
  logic [NS*MW-1:0]  s_mid;
  logic [NS*AW-1:0]  s_addr;
  logic [NS*DW-1:0]  s_wdata, s_rdata;

  int checks = 0, errors = 0;

  xbar_switch u_xbar_switch (
    .clk(clk), .rst_n(rst_n), .cfg_rr(cfg_rr), .cfg_prio(cfg_prio),
    .m_req(m_req), .m_elev(m_elev), .m_addr(m_addr), .m_we(m_we),
    .m_wdata(m_wdata), .m_last(m_last), .m_ready(m_ready), .m_err(m_err),
    .m_rdata(m_rdata), .s_sel(s_sel), .s_mid(s_mid), .s_addr(s_addr),
    .s_we(s_we), .s_wdata(s_wdata), .s_last(s_last), .s_ready(s_ready),
    .s_rdata(s_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // slave responders: read data tags the port and echoes the address
  always_comb begin
    for (int s = 0; s < NS; s++)
      s_rdata[s*DW +: DW] = {8'(s + 1), 24'h0, s_addr[s*AW +: AW]};
  end

  task automatic chk(string tag, bit ok, longint unsigned act, longint unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // scoreboard of expected grants {slave, master}
  logic [3:0] expq[$];
  logic [NS-1:0] sel_prev;

  task automatic expect_grant(int s, int m);
    expq.push_back({2'(s), 2'(m)});
  endtask

  always @(negedge clk) begin
    if (!rst_n) sel_prev <= '0;
    else begin
      for (int s = 0; s < NS; s++) begin
        if (s_sel[s] && !sel_prev[s]) begin
          if (expq.size() == 0) chk("R5/R6/R7 unexpected grant", 1'b0, s, 4'hf);
          else begin
            logic [3:0] e;
            e = expq.pop_front();
            chk("R5/R6/R7 grant order", (e[3:2] == 2'(s)) && (e[1:0] == s_mid[s*MW +: MW]),
                {2'(s), s_mid[s*MW +: MW]}, e);
          end
        end
      end
      sel_prev <= s_sel;
    end
  end

  task automatic set_prio(int s, int l0, int l1, int l2, int l3);
    cfg_prio[(s*NM+0)*2 +: 2] = 2'(l0);
    cfg_prio[(s*NM+1)*2 +: 2] = 2'(l1);
    cfg_prio[(s*NM+2)*2 +: 2] = 2'(l2);
    cfg_prio[(s*NM+3)*2 +: 2] = 2'(l3);
  endtask

  task automatic issue(int m, logic [31:0] a, bit last);
    m_addr[m*AW +: AW] = a;
    m_last[m] = last;
    m_req[m] = 1'b1;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // release each master after its last beat is accepted
  task automatic drain();
    logic [NM-1:0] fin;
    for (int c = 0; c < 200 && m_req != '0; c++) begin
      @(negedge clk);
      fin = m_ready & m_req & m_last;
      step();
      m_req  = m_req & ~fin;
      m_elev = m_elev & ~fin;
    end
    step();
  endtask

  initial begin
    #500000;
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_rr = '0; cfg_prio = '0;
    m_req = '0; m_elev = '0; m_addr = '0; m_we = '0; m_wdata = '0; m_last = '0;
    s_ready = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R3 reset idle s_sel", s_sel == '0, s_sel, 0);
    chk("R9 reset m_ready", m_ready == '0, m_ready, 0);

    // R2: unmapped region 0x3
    issue(1, 32'h3000_0040, 1'b1);
    #1;
    chk("R2 err flag", m_err[1] == 1'b1, m_err, 4'b0010);
    chk("R2 ready with err", m_ready[1] == 1'b1, m_ready, 4'b0010);
    step();
    chk("R2 no port held", s_sel == '0, s_sel, 0);
    m_req[1] = 1'b0;
    step();

    // R1/R3/R9: single write to slave 1 with slave stalled
    m_we[2] = 1'b1;
    m_wdata[2*DW +: DW] = 64'hA5A5_0000_1234_5678;
    expect_grant(1, 2);
    issue(2, 32'h2000_0010, 1'b1);
    #1;
    chk("R3 not granted same cycle", s_sel[1] == 1'b0, s_sel, 0);
    step();
    chk("R1 R3 slave1 selected", s_sel == 3'b010, s_sel, 3'b010);
    chk("R3 owner id", s_mid[1*MW +: MW] == 2'd2, s_mid[1*MW +: MW], 2);
    chk("R9 addr routed", s_addr[1*AW +: AW] == 32'h2000_0010, s_addr[1*AW +: AW], 32'h2000_0010);
    chk("R9 wdata routed", s_wdata[1*DW +: DW] == 64'hA5A5_0000_1234_5678,
        s_wdata[1*DW +: DW], 64'hA5A5_0000_1234_5678);
    chk("R9 we routed", s_we[1] == 1'b1, s_we, 3'b010);
    chk("R9 wait while slave stalls", m_ready[2] == 1'b0, m_ready, 0);
    s_ready[1] = 1'b1;
    #1;
    chk("R9 ready to owner", m_ready == 4'b0100, m_ready, 4'b0100);
    chk("R9 rdata to owner", m_rdata[2*DW +: DW] == {8'd2, 24'h0, 32'h2000_0010},
        m_rdata[2*DW +: DW], {8'd2, 24'h0, 32'h2000_0010});
    step();
    m_req[2] = 1'b0; m_we[2] = 1'b0;
    chk("R4 released after last", s_sel[1] == 1'b0, s_sel, 0);
    step();
    s_ready = '1;

    // R5: programmed order on slave 0, levels m0=0 m1=3 m2=1 m3=2
    set_prio(0, 0, 3, 1, 2);
    expect_grant(0, 1); expect_grant(0, 3); expect_grant(0, 2); expect_grant(0, 0);
    for (int m = 0; m < NM; m++) issue(m, 32'h0000_0100 + 32'(m), 1'b1);
    drain();

    // R6: rotating on slave 1, last granted there was master 2
    cfg_rr[1] = 1'b1;
    expect_grant(1, 3); expect_grant(1, 0); expect_grant(1, 1); expect_grant(1, 2);
    for (int m = 0; m < NM; m++) issue(m, 32'h2000_0200 + 32'(m), 1'b1);
    drain();
    expect_grant(1, 0); expect_grant(1, 2);
    issue(0, 32'h2000_0300, 1'b1); issue(2, 32'h2000_0304, 1'b1);
    drain();

    // R7: elevation on slave 2, fixed order m0=3 m1=2 m2=1 m3=0
    set_prio(2, 3, 2, 1, 0);
    expect_grant(2, 2); expect_grant(2, 3); expect_grant(2, 0);
    m_elev = 4'b1100;
    issue(0, 32'h4000_0000, 1'b1); issue(2, 32'h4000_0008, 1'b1); issue(3, 32'h4000_000C, 1'b1);
    drain();
    // R7 with R6: rotating tie-break among elevated, last granted is master 0
    cfg_rr[2] = 1'b1;
    expect_grant(2, 1); expect_grant(2, 0); expect_grant(2, 3);
    m_elev = 4'b0011;
    issue(0, 32'h4000_0100, 1'b1); issue(1, 32'h4000_0104, 1'b1); issue(3, 32'h4000_010C, 1'b1);
    drain();

    // R4: multi-beat owner is not preempted by a higher level
    expect_grant(0, 0); expect_grant(0, 1);
    issue(0, 32'h0000_0400, 1'b0);
    step();
    chk("R4 initial owner", s_sel[0] && s_mid[0 +: MW] == 2'd0, s_mid[0 +: MW], 0);
    issue(1, 32'h0000_0500, 1'b1);
    for (int c = 0; c < 3; c++) begin
      step();
      chk("R4 owner kept mid transaction", s_sel[0] && s_mid[0 +: MW] == 2'd0, s_mid[0 +: MW], 0);
    end
    m_last[0] = 1'b1;
    step();
    m_req[0] = 1'b0;
    chk("R4 idle cycle after last beat", s_sel[0] == 1'b0, s_sel, 0);
    step();
    chk("R4 waiter granted", s_sel[0] && s_mid[0 +: MW] == 2'd1, s_mid[0 +: MW], 1);
    step();
    m_req[1] = 1'b0;
    step();

    // R8: three ports in parallel
    s_ready = '0;
    expect_grant(0, 0); expect_grant(1, 1); expect_grant(2, 2);
    issue(0, 32'h0000_0800, 1'b1); issue(1, 32'h2000_0800, 1'b1); issue(2, 32'h4000_0800, 1'b1);
    step();
    chk("R8 all ports selected", s_sel == 3'b111, s_sel, 3'b111);
    chk("R8 owners", s_mid == {2'd2, 2'd1, 2'd0}, s_mid, {2'd2, 2'd1, 2'd0});
    s_ready = '1;
    #1;
    chk("R8 R9 parallel ready", m_ready == 4'b0111, m_ready, 4'b0111);
    drain();

    repeat (3) step();
    chk("R5/R6/R7 scoreboard drained", expq.size() == 0, expq.size(), 0);
    finish_run();
  end
endmodule